// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

A purely combinational arithmetic and logic unit for a 16-bit microcontroller datapath. Each evaluation takes a destination operand, a source operand, a 4-bit operation code, a size select (byte or word) and the incoming carry flag. It returns the result, a status vector holding the new flag values, a second status vector marking which flags the operation updates, and a write strobe that says whether the result should be stored.

The unit covers binary add and subtract (with and without carry), compare, packed-decimal add, the bitwise operations (and, test, clear, set, exclusive-or) and the single-operand shifts and conversions (rotate through carry, a rotate that shifts in zero, arithmetic shift, half swap, sign extension). Subtraction is formed as destination plus the inverted source plus one, so a set carry means no borrow. Operand fetch, register storage and write-back belong to the surrounding core.

Top module: `byte_word_alu`

## Requirements
- R1: Operation codes are ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, DADD=5, AND=6, BIT=7, BIC=8, BIS=9, XOR=10, RRC=11, RRZ=12, RRA=13, SWPB=14, SXT=15; in both status vectors C sits at bit 0, Z at bit 1, N at bit 2 and V at bit 8, all other bits zero. Whenever N and Z are updated, N equals the top bit of the result at the operation size and Z is set exactly when the size-masked result is zero.
- R2: ADD returns dst+src and ADDC returns dst+src+carry-in at the operation size; C is the carry out of that size and V is set when the signed sum leaves the signed range of that size.
- R3: SUB returns dst+~src+1, SUBC returns dst+~src+carry-in (both at size); C is the carry out of the size (set = no borrow) and V is signed overflow of the difference; CMP produces the same result and flags as SUB.
- R4: DADD adds dst, src and carry-in digit by digit as packed decimal; C is set when the decimal sum exceeds 99 in byte mode or 9999 in word mode, and V is cleared.
- R5: AND and BIT return dst&src, set C when the result is non-zero and clear V.
- R6: BIC returns dst&~src and BIS returns dst|src; neither updates any flag (update vector zero).
- R7: XOR returns dst^src, sets C when the result is non-zero and sets V only when both operands are negative at the operation size.
- R8: RRC shifts dst right by one at size, moving the old carry into the top bit and the old LSB into C; RRZ does the same but shifts in 0; V is cleared.
- R9: RRA shifts dst right by one at size keeping the sign bit, moves the old LSB into C and clears V.
- R10: SWPB exchanges the two bytes of the word dst and updates no flag.
- R11: SXT always yields a word: bit 7 of dst copied into bits 15..8 over dst[7:0]; N and Z follow the word result, C is set when it is non-zero, V is cleared, regardless of the size select.
- R12: In byte mode bits 15..8 of the result are zero for every operation except SXT.
- R13: The write strobe is low for CMP and BIT and high for every other operation; the flag value vector is zero in every bit the update vector does not mark; ADD..DADD, AND, BIT, XOR, RRC, RRZ, RRA and SXT update all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1 encoding) |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| cin_i | input | 1 | Current carry flag |
| dst_i | input | 16 | Destination operand (sole operand of single-operand codes) |
| src_i | input | 16 | Source operand |
| res_o | output | 16 | Result |
| flag_val_o | output | 9 | New flag values in status layout |
| flag_upd_o | output | 9 | Flags this operation updates, status layout |
| res_wr_o | output | 1 | Result should be written back |

## Verification
The bench builds the unit with its defaults: a 16-bit datapath, the decimal adder present and the status layout C/Z/N/V at bits 0/1/2/8. That brings every operation code within reach in both sizes, including the carry and overflow edges at 0x7F/0xFF and 0x7FFF/0xFFFF, the decimal carry threshold at 99 and 9999, and the size-select override for sign extension. A scoreboard compares result, both status vectors and the write strobe against an integer model for directed corner cases and a few thousand random operand sets, with decimal operands drawn as valid digit strings.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDC = 4'd1,
      OP_SUB  = 4'd2,
      OP_SUBC = 4'd3,
      OP_CMP  = 4'd4,
      OP_DADD = 4'd5,
      OP_AND  = 4'd6,
      OP_BIT  = 4'd7,
      OP_BIC  = 4'd8,
      OP_BIS  = 4'd9,
      OP_XOR  = 4'd10,
      OP_RRC  = 4'd11,
      OP_RRZ  = 4'd12,
      OP_RRA  = 4'd13,
      OP_SWPB = 4'd14,
      OP_SXT  = 4'd15
   } alu_op_e;

   // Per-operation attributes: does it touch the flags, is the result
   // stored, and is C taken from "result non-zero".
   typedef struct packed {
      logic upd;
      logic wr;
      logic c_nz;
   } op_attr_t;

   function automatic op_attr_t op_attr(alu_op_e op);
      op_attr_t a;
      a.upd  = 1'b1;
      a.wr   = 1'b1;
      a.c_nz = 1'b0;
      case (op)
         OP_CMP:                   a.wr = 1'b0;
         OP_BIT:                   begin a.wr = 1'b0; a.c_nz = 1'b1; end
         OP_AND, OP_XOR, OP_SXT:   a.c_nz = 1'b1;
         OP_BIC, OP_BIS, OP_SWPB:  a.upd = 1'b0;
         default:                  ;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/alu_adder.sv
// Binary adder shared by add, add-with-carry, subtract, subtract-with-carry
// and compare. Operands arrive already masked (and, for subtraction,
// inverted) to the operation size.
module alu_adder #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              byte_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o,
   output logic              ovf_o
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W:0] ext;
   logic            sa, sb, ss;

   assign ext    = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
   assign sum_o  = ext[DATA_W-1:0];
   assign cout_o = byte_i ? ext[HALF_W] : ext[DATA_W];

   assign sa = byte_i ? a_i[HALF_W-1] : a_i[DATA_W-1];
   assign sb = byte_i ? b_i[HALF_W-1] : b_i[DATA_W-1];
   assign ss = byte_i ? ext[HALF_W-1] : ext[DATA_W-1];

   // Same-signed inputs giving a differently signed sum.
   assign ovf_o = (sa == sb) && (ss != sa);
endmodule

// File: rtl/alu_bcd.sv
// Packed-decimal adder: a ripple of per-digit adders, each correcting
// by six when its binary digit sum passes nine.
module alu_bcd #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              byte_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o
);
   localparam int DIGITS      = DATA_W / 4;
   localparam int BYTE_DIGITS = DIGITS / 2;

   logic [DIGITS:0] dcarry;
   assign dcarry[0] = cin_i;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      logic [4:0] raw;
      logic [4:0] fixed;
      logic       over;
      assign raw   = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, dcarry[g]};
      assign over  = raw > 5'd9;
      assign fixed = raw + 5'd6;
      assign sum_o[4*g +: 4] = over ? fixed[3:0] : raw[3:0];
      assign dcarry[g+1] = over;
   end

   assign cout_o = byte_i ? dcarry[BYTE_DIGITS] : dcarry[DIGITS];
endmodule

// File: rtl/alu_unary.sv
// Single-operand shifters and converters.
module alu_unary #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic              cin_i,
   input  logic              byte_i,
   output logic [DATA_W-1:0] rrc_o,
   output logic [DATA_W-1:0] rrz_o,
   output logic [DATA_W-1:0] rra_o,
   output logic [DATA_W-1:0] swp_o,
   output logic [DATA_W-1:0] sxt_o,
   output logic              lsb_o
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] rrc_w, rrc_b, rrz_w, rrz_b, rra_w, rra_b;

   assign rrc_w = {cin_i, val_i[DATA_W-1:1]};
   assign rrc_b = {{HALF_W{1'b0}}, cin_i, val_i[HALF_W-1:1]};
   assign rrz_w = {1'b0, val_i[DATA_W-1:1]};
   assign rrz_b = {{HALF_W{1'b0}}, 1'b0, val_i[HALF_W-1:1]};
   assign rra_w = {val_i[DATA_W-1], val_i[DATA_W-1:1]};
   assign rra_b = {{HALF_W{1'b0}}, val_i[HALF_W-1], val_i[HALF_W-1:1]};

   assign rrc_o = byte_i ? rrc_b : rrc_w;
   assign rrz_o = byte_i ? rrz_b : rrz_w;
   assign rra_o = byte_i ? rra_b : rra_w;
   assign swp_o = {val_i[HALF_W-1:0], val_i[DATA_W-1:HALF_W]};
   assign sxt_o = {{HALF_W{val_i[HALF_W-1]}}, val_i[HALF_W-1:0]};
   assign lsb_o = val_i[0];
endmodule

// File: rtl/byte_word_alu.sv
module byte_word_alu
   import alu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int STAT_W      = 9,
   parameter int C_POS       = 0,
   parameter int Z_POS       = 1,
   parameter int N_POS       = 2,
   parameter int V_POS       = 8,
   parameter bit HAS_DECIMAL = 1'b1
) (
   input  logic [3:0]        op_i,
   input  logic              byte_i,
   input  logic              cin_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] res_o,
   output logic [STAT_W-1:0] flag_val_o,
   output logic [STAT_W-1:0] flag_upd_o,
   output logic              res_wr_o
);
   localparam int HALF_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("byte_word_alu: DATA_W must be a multiple of 8 and at least 16");
   end
   if (C_POS >= STAT_W || Z_POS >= STAT_W || N_POS >= STAT_W || V_POS >= STAT_W) begin : g_bad_pos
      $error("byte_word_alu: flag position outside status width");
   end
   if (C_POS == Z_POS || C_POS == N_POS || C_POS == V_POS ||
       Z_POS == N_POS || Z_POS == V_POS || N_POS == V_POS) begin : g_dup_pos
      $error("byte_word_alu: flag positions must be distinct");
   end

   alu_op_e  op;
   op_attr_t attr;
   assign op   = alu_op_e'(op_i);
   assign attr = op_attr(op);

   // Operand conditioning
   logic [DATA_W-1:0] size_mask, d_m, s_m, s_inv;
   logic              d_sign, s_sign;

   assign size_mask = byte_i ? LOW_MASK : {DATA_W{1'b1}};
   assign d_m       = dst_i & size_mask;
   assign s_m       = src_i & size_mask;
   assign s_inv     = ~src_i & size_mask;
   assign d_sign    = byte_i ? dst_i[HALF_W-1] : dst_i[DATA_W-1];
   assign s_sign    = byte_i ? src_i[HALF_W-1] : src_i[DATA_W-1];

   // Binary adder path
   logic [DATA_W-1:0] add_b, add_sum;
   logic              add_cin, add_cout, add_ovf, is_sub;

   assign is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
   assign add_b  = is_sub ? s_inv : s_m;

   always_comb begin
      case (op)
         OP_ADDC, OP_SUBC: add_cin = cin_i;
         OP_SUB, OP_CMP:   add_cin = 1'b1;
         default:          add_cin = 1'b0;
      endcase
   end

   alu_adder #(.DATA_W(DATA_W)) u_adder (
      .a_i    (d_m),
      .b_i    (add_b),
      .cin_i  (add_cin),
      .byte_i (byte_i),
      .sum_o  (add_sum),
      .cout_o (add_cout),
      .ovf_o  (add_ovf)
   );

   // Decimal path, present or absent by parameter
   logic [DATA_W-1:0] bcd_sum;
   logic              bcd_cout;

   if (HAS_DECIMAL) begin : g_decimal
      alu_bcd #(.DATA_W(DATA_W)) u_bcd (
         .a_i    (d_m),
         .b_i    (s_m),
         .cin_i  (cin_i),
         .byte_i (byte_i),
         .sum_o  (bcd_sum),
         .cout_o (bcd_cout)
      );
   end else begin : g_no_decimal
      assign bcd_sum  = '0;
      assign bcd_cout = 1'b0;
   end

   // Single-operand path
   logic [DATA_W-1:0] rrc_res, rrz_res, rra_res, swp_res, sxt_res;
   logic              old_lsb;

   alu_unary #(.DATA_W(DATA_W)) u_unary (
      .val_i  (dst_i),
      .cin_i  (cin_i),
      .byte_i (byte_i),
      .rrc_o  (rrc_res),
      .rrz_o  (rrz_res),
      .rra_o  (rra_res),
      .swp_o  (swp_res),
      .sxt_o  (sxt_res),
      .lsb_o  (old_lsb)
   );

   // Result select
   logic [DATA_W-1:0] raw_res;
   logic              raw_c, raw_v;

   always_comb begin
      raw_res = '0;
      raw_c   = 1'b0;
      raw_v   = 1'b0;
      case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
            raw_res = add_sum;
            raw_c   = add_cout;
            raw_v   = add_ovf;
         end
         OP_DADD: begin
            raw_res = bcd_sum;
            raw_c   = bcd_cout;
         end
         OP_AND, OP_BIT: raw_res = d_m & s_m;
         OP_BIC:         raw_res = d_m & ~s_m;
         OP_BIS:         raw_res = d_m | s_m;
         OP_XOR: begin
            raw_res = d_m ^ s_m;
            raw_v   = d_sign & s_sign;
         end
         OP_RRC: begin raw_res = rrc_res; raw_c = old_lsb; end
         OP_RRZ: begin raw_res = rrz_res; raw_c = old_lsb; end
         OP_RRA: begin raw_res = rra_res; raw_c = old_lsb; end
         OP_SWPB:        raw_res = swp_res;
         OP_SXT:         raw_res = sxt_res;
         default:        ;
      endcase
   end

   // Size handling and flag formation
   logic eff_byte, neg, zero, carry, upd;

   assign eff_byte = byte_i && (op != OP_SXT);
   assign res_o    = eff_byte ? (raw_res & LOW_MASK) : raw_res;
   assign neg      = eff_byte ? res_o[HALF_W-1] : res_o[DATA_W-1];
   assign zero     = ~|res_o;
   assign carry    = attr.c_nz ? ~zero : raw_c;
   assign upd      = attr.upd && (HAS_DECIMAL || (op != OP_DADD));
   assign res_wr_o = attr.wr;

   always_comb begin
      flag_val_o = '0;
      flag_upd_o = '0;
      if (upd) begin
         flag_upd_o[C_POS] = 1'b1;
         flag_upd_o[Z_POS] = 1'b1;
         flag_upd_o[N_POS] = 1'b1;
         flag_upd_o[V_POS] = 1'b1;
         flag_val_o[C_POS] = carry;
         flag_val_o[Z_POS] = zero;
         flag_val_o[N_POS] = neg;
         flag_val_o[V_POS] = raw_v;
      end
   end
endmodule

// File: rtl/byte_word_alu_chk.sv
module byte_word_alu_chk
   import alu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int STAT_W = 9,
   parameter int C_POS  = 0,
   parameter int Z_POS  = 1,
   parameter int N_POS  = 2,
   parameter int V_POS  = 8
) (
   input logic [3:0]        op_i,
   input logic              byte_i,
   input logic              cin_i,
   input logic [DATA_W-1:0] dst_i,
   input logic [DATA_W-1:0] src_i,
   input logic [DATA_W-1:0] res_o,
   input logic [STAT_W-1:0] flag_val_o,
   input logic [STAT_W-1:0] flag_upd_o,
   input logic              res_wr_o
);
   localparam int HALF_W = DATA_W / 2;

   logic              known, word_res, size_neg, size_zero;
   logic              dneg, sneg;
   logic [DATA_W-1:0] upper;

   assign known     = !$isunknown({op_i, byte_i, cin_i, dst_i, src_i});
   assign word_res  = !byte_i || (op_i == OP_SXT);
   assign upper     = res_o >> HALF_W;
   assign size_neg  = word_res ? res_o[DATA_W-1] : res_o[HALF_W-1];
   assign size_zero = word_res ? (res_o == '0) : (res_o[HALF_W-1:0] == '0);
   assign dneg      = byte_i ? dst_i[HALF_W-1] : dst_i[DATA_W-1];
   assign sneg      = byte_i ? src_i[HALF_W-1] : src_i[DATA_W-1];

   always_comb begin
      if (known) begin
         a_r12_byte_upper_zero: assert (word_res || upper == '0)
            else $error("R12: byte result has upper bits set");
         a_r6_no_flag_update: assert (!(op_i == OP_BIC || op_i == OP_BIS || op_i == OP_SWPB)
                                      || flag_upd_o == '0)
            else $error("R6/R10: flag update on a no-flag operation");
         a_r13_write_strobe: assert (res_wr_o == !(op_i == OP_CMP || op_i == OP_BIT))
            else $error("R13: write strobe wrong");
         a_r13_val_in_mask: assert ((flag_val_o & ~flag_upd_o) == '0)
            else $error("R13: flag value outside update mask");
         a_r1_zero_flag: assert (!flag_upd_o[Z_POS] || flag_val_o[Z_POS] == size_zero)
            else $error("R1: Z does not follow the result");
         a_r1_neg_flag: assert (!flag_upd_o[N_POS] || flag_val_o[N_POS] == size_neg)
            else $error("R1: N does not follow the result");
         a_r5_logic_carry: assert (!(op_i == OP_AND || op_i == OP_BIT)
                                   || flag_val_o[C_POS] == !size_zero)
            else $error("R5: carry of logic op wrong");
         a_r7_xor_overflow: assert (op_i != OP_XOR || flag_val_o[V_POS] == (dneg && sneg))
            else $error("R7: xor overflow wrong");
         a_r11_sxt_upper: assert (op_i != OP_SXT || upper == {DATA_W{dst_i[HALF_W-1]}} >> HALF_W)
            else $error("R11: sign extension upper half wrong");
      end
   end
endmodule

bind byte_word_alu byte_word_alu_chk #(
   .DATA_W (DATA_W),
   .STAT_W (STAT_W),
   .C_POS  (C_POS),
   .Z_POS  (Z_POS),
   .N_POS  (N_POS),
   .V_POS  (V_POS)
) chk_i (
   .op_i       (op_i),
   .byte_i     (byte_i),
   .cin_i      (cin_i),
   .dst_i      (dst_i),
   .src_i      (src_i),
   .res_o      (res_o),
   .flag_val_o (flag_val_o),
   .flag_upd_o (flag_upd_o),
   .res_wr_o   (res_wr_o)
);

// File: tb/byte_word_alu_tb_top.sv
module byte_word_alu_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op_i = 4'd0;
   logic        byte_i = 1'b0;
   logic        cin_i = 1'b0;
   logic [15:0] dst_i = 16'd0;
   logic [15:0] src_i = 16'd0;
   logic [15:0] res_o;
   logic [8:0]  flag_val_o;
   logic [8:0]  flag_upd_o;
   logic        res_wr_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   byte_word_alu dut_i (
      .op_i       (op_i),
      .byte_i     (byte_i),
      .cin_i      (cin_i),
      .dst_i      (dst_i),
      .src_i      (src_i),
      .res_o      (res_o),
      .flag_val_o (flag_val_o),
      .flag_upd_o (flag_upd_o),
      .res_wr_o   (res_wr_o)
   );

   typedef struct {
      int    op;
      string tag;
      int    res;
      int    fv;
      int    fu;
      bit    wr;
   } item_t;

   item_t sb_q[$];

   function automatic string op_tag(int op);
      case (op)
         0, 1:    return "R2";
         2, 3, 4: return "R3";
         5:       return "R4";
         6, 7:    return "R5";
         8, 9:    return "R6";
         10:      return "R7";
         11, 12:  return "R8";
         13:      return "R9";
         14:      return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic int dec_val(int x);
      int acc = 0;
      int scale = 1;
      for (int i = 0; i < 4; i++) begin
         acc += ((x >> (4*i)) & 15) * scale;
         scale *= 10;
      end
      return acc;
   endfunction

   function automatic int enc_val(int x);
      int acc = 0;
      int rem = x;
      for (int i = 0; i < 4; i++) begin
         acc |= (rem % 10) << (4*i);
         rem /= 10;
      end
      return acc;
   endfunction

   // Integer reference model built from the requirements
   function automatic item_t model(int op, int d, int s, bit by, bit ci, string tag);
      item_t it;
      int w  = by ? 8 : 16;
      int m  = (1 << w) - 1;
      int sg = 1 << (w - 1);
      int dm = d & m;
      int sm = s & m;
      int sd = (dm & sg) != 0 ? dm - (1 << w) : dm;
      int ss = (sm & sg) != 0 ? sm - (1 << w) : sm;
      int u = 0, r = 0, sr = 0, fw = w, bin = 0, lim = 0;
      bit c = 0, v = 0, n, z, upd = 1, wr = 1;
      case (op)
         0, 1: begin
            u = dm + sm + ((op == 1) ? int'(ci) : 0);
            sr = sd + ss + ((op == 1) ? int'(ci) : 0);
            r = u & m; c = u > m; v = (sr < -sg) || (sr >= sg);
         end
         2, 3, 4: begin
            u = dm + ((~s) & m) + ((op == 3) ? int'(ci) : 1);
            sr = sd - ss - ((op == 3) ? 1 - int'(ci) : 0);
            r = u & m; c = u > m; v = (sr < -sg) || (sr >= sg);
            wr = (op != 4);
         end
         5: begin
            lim = by ? 100 : 10000;
            bin = dec_val(dm) + dec_val(sm) + int'(ci);
            c = bin >= lim; r = enc_val(bin % lim);
         end
         6, 7: begin r = dm & sm; c = r != 0; wr = (op != 7); end
         8: begin r = dm & ~sm & m; upd = 0; end
         9: begin r = dm | sm; upd = 0; end
         10: begin r = dm ^ sm; c = r != 0; v = (sd < 0) && (ss < 0); end
         11: begin r = (dm >> 1) | (ci ? sg : 0); c = dm & 1; end
         12: begin r = dm >> 1; c = dm & 1; end
         13: begin r = (dm >> 1) | (dm & sg); c = dm & 1; end
         14: begin r = (((d >> 8) & 255) | ((d & 255) << 8)) & m; upd = 0; end
         default: begin
            r = ((d & 128) != 0) ? ((d & 255) | 'hFF00) : (d & 255);
            fw = 16; c = r != 0;
         end
      endcase
      n = ((r >> (fw - 1)) & 1) != 0;
      z = (r == 0);
      it.op  = op;
      it.tag = tag;
      it.res = r;
      it.wr  = wr;
      it.fu  = upd ? 'h107 : 0;
      it.fv  = upd ? ((int'(v) << 8) | (int'(n) << 2) | (int'(z) << 1) | int'(c)) : 0;
      return it;
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // Driver: applies one operation and pushes its expectation
   task automatic drive(int op, int d, int s, bit by, bit ci, string tag);
      @(posedge clk);
      #1;
      op_i   = 4'(op);
      dst_i  = 16'(d);
      src_i  = 16'(s);
      byte_i = by;
      cin_i  = ci;
      sb_q.push_back(model(op, d, s, by, ci, tag));
   endtask

   // Monitor: pops and compares mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(int'(res_o) == it.res, it.tag, "result", int'(res_o), it.res);
            check(int'(flag_val_o) == it.fv, it.tag, "flag values", int'(flag_val_o), it.fv);
            check(int'(flag_upd_o) == it.fu, it.tag, "flag update", int'(flag_upd_o), it.fu);
            check(res_wr_o == it.wr, (it.op == 4 || it.op == 7) ? "R13" : it.tag,
                  "write strobe", int'(res_wr_o), int'(it.wr));
         end
      end
   end

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   function automatic int rand_bcd(bit by);
      return enc_val(by ? int'($urandom % 100) : int'($urandom % 10000));
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R1: idle state, all-zero inputs (ADD of zeros -> Z only)
      drive(0, 'h0000, 'h0000, 0, 0, "R1");
      // R2: signed overflow and carry edges
      drive(0, 'h7FFF, 'h0001, 0, 0, "R2");
      drive(0, 'hFFFF, 'h0001, 0, 0, "R2");
      drive(1, 'h7FFE, 'h0001, 0, 1, "R2");
      // R12: byte add with junk in upper bits
      drive(0, 'hABFF, 'hCD01, 1, 0, "R12");
      drive(0, 'h007F, 'h0001, 1, 0, "R2");
      // R3: subtract / compare
      drive(2, 'h0005, 'h0005, 0, 0, "R3");
      drive(2, 'h0000, 'h0001, 0, 0, "R3");
      drive(2, 'h8000, 'h0001, 0, 0, "R3");
      drive(3, 'h0005, 'h0005, 0, 0, "R3");
      drive(4, 'h1234, 'h1235, 0, 0, "R13");
      drive(3, 'h0080, 'h0001, 1, 1, "R3");
      // R4: decimal carry thresholds
      drive(5, 'h0099, 'h0001, 1, 0, "R4");
      drive(5, 'h9999, 'h0001, 0, 0, "R4");
      drive(5, 'h1234, 'h4321, 0, 1, "R4");
      drive(5, 'h0049, 'h0050, 1, 0, "R4");
      // R5 / R6 / R7
      drive(6, 'hF0F0, 'h0F0F, 0, 0, "R5");
      drive(7, 'h8001, 'h8000, 0, 1, "R13");
      drive(8, 'hFFFF, 'h00F0, 0, 1, "R6");
      drive(9, 'h1200, 'h0034, 1, 1, "R6");
      drive(10, 'h8000, 'h8001, 0, 0, "R7");
      drive(10, 'h0080, 'h0080, 1, 0, "R7");
      // R8 / R9
      drive(11, 'h0001, 'h0000, 0, 1, "R8");
      drive(12, 'h0001, 'h0000, 0, 1, "R8");
      drive(11, 'hFF02, 'h0000, 1, 1, "R8");
      drive(13, 'h8002, 'h0000, 0, 0, "R9");
      drive(13, 'h0081, 'h0000, 1, 0, "R9");
      // R10 / R11 / R12
      drive(14, 'h12AB, 'h0000, 0, 0, "R10");
      drive(14, 'h12AB, 'h0000, 1, 0, "R12");
      drive(15, 'h0080, 'h0000, 1, 0, "R11");
      drive(15, 'h557F, 'h0000, 0, 0, "R11");
      drive(15, 'hFF00, 'h0000, 1, 0, "R11");

      // Random sweep over all operations and both sizes
      for (int i = 0; i < 3000; i++) begin
         int op = int'($urandom % 16);
         bit by = 1'($urandom);
         bit ci = 1'($urandom);
         int d, s;
         if (op == 5) begin
            d = rand_bcd(by) | (by ? int'($urandom & 'hFF00) : 0);
            s = rand_bcd(by);
         end else begin
            d = int'($urandom & 'hFFFF);
            s = int'($urandom & 'hFFFF);
         end
         drive(op, d, s, by, ci, op_tag(op));
      end

      repeat (4) @(posedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule